// File: doc/BRIEF.md
# Instruction Field Decoder

This block classifies one 32-bit fixed-length instruction word per accepted strobe and prepares its operands. It splits the word into the fields of three layouts: register-immediate, register-register and long-jump. It looks up the six-bit primary opcode in a first table. One primary value hands the word to a second table indexed by an extended opcode.

Every table entry gives an operation class, the extension mode for the immediate, a destination selector and a privilege mark. From these the block produces a compact operation identifier, a 32-bit resolved immediate, the three raw register indices, a destination index with a write enable, and three mutually exclusive fault flags: illegal, unimplemented and privilege violation.

A pipeline front end feeds it words together with the current user-mode flag. The results appear one clock later, and the execution stage consumes them. Executing the operation, reading registers, accessing memory and taking exceptions are left to other blocks.

Top module: `insn_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to zero on that edge, including `out_valid`.
- R2: A word presented with `in_valid` high is decoded onto the outputs at the next rising edge, and `out_valid` is high for that one cycle. After an edge where `in_valid` is low, `out_valid` is low and the decoded outputs keep their previous values.
- R3: `reg_a` is word bits [31:27], `reg_b` is bits [26:22] and `reg_c` is bits [21:17]. They are reported for every accepted word, whatever its layout.
- R4: Non-faulting, non-no-op primary opcodes are reported as `op_id = {1'b0, opcode}`. The opcode is bits [5:0]. The primary opcodes that decode are 0, 1, 3-8, 11-16, 20-24, 28, 30, 32, 36, 38, 40, 44, 46, 48, 52, 54, 56 and 60. The I/O variants 35, 37, 39, 43, 45, 47, 53 and 55 report the opcode 32 lower.
- R5: Primary opcode 58 selects the register-register layout. A decoded extended opcode `x` (bits [16:11]) is reported as `op_id = {1'b1, x}`. The extended opcodes that decode are 1, 2, 3, 5-9, 11, 13, 14, 16, 18-20, 22-24, 26-32, 36-40, 45, 46, 48, 49, 52, 54 and 57-59.
- R6: Bits [21:6] are sign-extended into `imm` for the following: loads, stores, branches (6, 14, 22, 30, 38, 46, 54), addi (4), muli (36), the signed compares (8, 16, 24, 32) and 56.
- R7: Bits [21:6] are zero-extended for opcodes 12, 20, 28, 40 and 48. Opcodes 0 and 1 zero-extend bits [31:6]. Register-register words zero-extend bits [10:6].
- R8: For opcodes 44, 52 and 60, `imm` is bits [21:6] placed in [31:16], with the low half zero.
- R9: The destination is `reg_b` for register-immediate loads and ALU operations. It is `reg_c` for writing register-register operations, and 31 for primary 0 and extended 29. `wr_en` is high only for a writing operation whose destination is not 0. Non-writing operations (stores, branches, 1, and extended 1, 5, 9, 13, 20, 45, 46, 52, 54) report `dest = 0`.
- R10: Primary opcodes 19, 27, 51 and 59 and extended opcodes 4, 12 and 41 are no-ops. They give `op_id = 7'h7F`, `imm = 0`, `dest = 0`, `wr_en = 0` and no fault flag.
- R11: Any other primary or extended opcode raises `fault_illegal`.
- R12: Primary opcode 50 raises `fault_unimpl`.
- R13: Primary 56 and extended 1, 9, 20, 38 and 46 raise `fault_priv` when `user_mode` is high. With `user_mode` low they decode normally.
- R14: A faulting word has exactly one fault flag high. It also gives `op_id = 7'h7F`, `imm = 0`, `dest = 0` and `wr_en = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: decode `insn` on this edge |
| insn | input | 32 | Instruction word |
| user_mode | input | 1 | High when the word runs in user mode |
| out_valid | output | 1 | Decoded result was captured on the last edge |
| op_id | output | 7 | Operation identifier (table select bit and opcode) |
| imm | output | 32 | Resolved immediate |
| reg_a | output | 5 | Register A field |
| reg_b | output | 5 | Register B field |
| reg_c | output | 5 | Register C field |
| dest | output | 5 | Destination register index |
| wr_en | output | 1 | Register write requested |
| fault_illegal | output | 1 | Opcode not defined |
| fault_unimpl | output | 1 | Opcode defined but not implemented |
| fault_priv | output | 1 | Privileged operation in user mode |

## Verification
Several properties are checked on every cycle:
- the one-cycle strobe timing and the holding of results while idle;
- that a fault flag never coexists with a write, a real identifier or a non-zero immediate;
- that at most one fault flag is set;
- that no write ever targets register 0;
- that a privilege fault only follows a word accepted in user mode.

The per-opcode classification needs the bench's scenarios: the table contents, the extension mode chosen for each opcode, the I/O-variant folding and the destination choice. Directed words cover the no-op, unimplemented, privileged and destination-zero corners, and seeded random words sweep both tables.

// File: rtl/insn_dec_pkg.sv
// Package: shared field positions, widths, entry types and an entry builder
// for the instruction field decoder. Assumes a 32-bit word with a 6-bit
// primary opcode in the low bits.
package insn_dec_pkg;

    localparam int WORD_W   = 32;
    localparam int OPC_W    = 6;
    localparam int REG_W    = 5;
    localparam int IMM_S_W  = 16;
    localparam int IMM_R_W  = 5;
    localparam int IMM_J_W  = WORD_W - OPC_W;
    localparam int OPID_W   = OPC_W + 1;

    localparam int OPC_LSB   = 0;
    localparam int IMM16_LSB = OPC_W;
    localparam int IMM5_LSB  = OPC_W;
    localparam int OPX_LSB   = IMM5_LSB + IMM_R_W;
    localparam int RC_LSB    = OPX_LSB + OPC_W;
    localparam int RB_LSB    = RC_LSB + REG_W;
    localparam int RA_LSB    = RB_LSB + REG_W;

    localparam logic [OPC_W-1:0]  OPC_RFMT = 6'h3A;
    localparam logic [OPID_W-1:0] OPID_NOP = '1;
    localparam logic [REG_W-1:0]  LINK_REG = '1;

    typedef enum logic [1:0] {
        CLS_OP, CLS_NOP, CLS_ILLEGAL, CLS_UNIMPL
    } insn_cls_e;

    typedef enum logic [2:0] {
        IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_HIGH, IMM_IMM5, IMM_IMM26
    } imm_mode_e;

    typedef enum logic [1:0] {
        DST_NONE, DST_B, DST_C, DST_LINK
    } dst_sel_e;

    typedef struct packed {
        insn_cls_e cls;
        imm_mode_e imm_mode;
        dst_sel_e  dst;
        logic      priv;
    } dec_entry_t;

    // Builds one table entry from its four attributes.
    function automatic dec_entry_t mk(insn_cls_e c, imm_mode_e m, dst_sel_e d, logic p);
        dec_entry_t e;
        e.cls = c;
        e.imm_mode = m;
        e.dst = d;
        e.priv = p;
        return e;
    endfunction

endpackage

// File: rtl/insn_fields.sv
// Module: splits an instruction word into all the fields of the three
// layouts at once. Assumes the fixed bit positions from the package;
// the caller chooses which fields are meaningful.
module insn_fields
    import insn_dec_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    output logic [OPC_W-1:0]   opc,
    output logic [OPC_W-1:0]   opx,
    output logic [REG_W-1:0]   ra,
    output logic [REG_W-1:0]   rb,
    output logic [REG_W-1:0]   rc,
    output logic [IMM_S_W-1:0] imm16,
    output logic [IMM_R_W-1:0] imm5,
    output logic [IMM_J_W-1:0] imm26
);

    // Pure bit slicing of the word into fields.
    always_comb begin
        opc   = word[OPC_LSB   +: OPC_W];
        opx   = word[OPX_LSB   +: OPC_W];
        ra    = word[RA_LSB    +: REG_W];
        rb    = word[RB_LSB    +: REG_W];
        rc    = word[RC_LSB    +: REG_W];
        imm16 = word[IMM16_LSB +: IMM_S_W];
        imm5  = word[IMM5_LSB  +: IMM_R_W];
        imm26 = word[IMM16_LSB +: IMM_J_W];
    end

endmodule

// File: rtl/insn_prim_tbl.sv
// Module: primary opcode table. Gives the entry for an opcode, the opcode
// with I/O variants folded onto their plain counterparts, and a flag for
// the escape to the extended table. Assumes the caller ignores the entry
// when the escape flag is set.
module insn_prim_tbl
    import insn_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output dec_entry_t       ent,
    output logic [OPC_W-1:0] opc_norm,
    output logic             is_rfmt
);

    logic io_variant;

    // Folds I/O load/store variants onto the plain opcode (32 lower).
    always_comb begin
        io_variant = opc inside {6'd35, 6'd37, 6'd39, 6'd43, 6'd45, 6'd47, 6'd53, 6'd55};
        opc_norm   = io_variant ? {1'b0, opc[OPC_W-2:0]} : opc;
        is_rfmt    = (opc == OPC_RFMT);
    end

    // Primary table lookup: class, immediate mode, destination, privilege.
    always_comb begin
        case (opc)
            6'd0:  ent = mk(CLS_OP, IMM_IMM26, DST_LINK, 1'b0);
            6'd1:  ent = mk(CLS_OP, IMM_IMM26, DST_NONE, 1'b0);
            6'd3, 6'd7, 6'd11, 6'd15, 6'd23,
            6'd35, 6'd39, 6'd43, 6'd47, 6'd55:
                   ent = mk(CLS_OP, IMM_SEXT, DST_B, 1'b0);
            6'd5, 6'd13, 6'd21, 6'd37, 6'd45, 6'd53:
                   ent = mk(CLS_OP, IMM_SEXT, DST_NONE, 1'b0);
            6'd6, 6'd14, 6'd22, 6'd30, 6'd38, 6'd46, 6'd54:
                   ent = mk(CLS_OP, IMM_SEXT, DST_NONE, 1'b0);
            6'd4, 6'd36, 6'd8, 6'd16, 6'd24, 6'd32:
                   ent = mk(CLS_OP, IMM_SEXT, DST_B, 1'b0);
            6'd12, 6'd20, 6'd28, 6'd40, 6'd48:
                   ent = mk(CLS_OP, IMM_ZEXT, DST_B, 1'b0);
            6'd44, 6'd52, 6'd60:
                   ent = mk(CLS_OP, IMM_HIGH, DST_B, 1'b0);
            6'd56: ent = mk(CLS_OP, IMM_SEXT, DST_B, 1'b1);
            6'd19, 6'd27, 6'd51, 6'd59:
                   ent = mk(CLS_NOP, IMM_NONE, DST_NONE, 1'b0);
            6'd50: ent = mk(CLS_UNIMPL, IMM_NONE, DST_NONE, 1'b0);
            6'd58: ent = mk(CLS_OP, IMM_NONE, DST_NONE, 1'b0);
            default:
                   ent = mk(CLS_ILLEGAL, IMM_NONE, DST_NONE, 1'b0);
        endcase
    end

endmodule

// File: rtl/insn_ext_tbl.sv
// Module: extended opcode table for the register-register layout. Every
// defined entry takes the 5-bit immediate zero-extended. Assumes it is
// consulted only when the primary opcode escapes to it.
module insn_ext_tbl
    import insn_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opx,
    output dec_entry_t       ent
);

    logic priv_op;

    // Marks the control-transfer and control-register operations as privileged.
    always_comb priv_op = opx inside {6'd1, 6'd9, 6'd20, 6'd38, 6'd46};

    // Extended table lookup.
    always_comb begin
        case (opx)
            6'd2, 6'd3, 6'd6, 6'd7, 6'd8, 6'd11, 6'd14, 6'd16, 6'd18, 6'd19,
            6'd22, 6'd23, 6'd24, 6'd26, 6'd27, 6'd28, 6'd30, 6'd31, 6'd32,
            6'd36, 6'd37, 6'd38, 6'd39, 6'd40, 6'd48, 6'd49, 6'd57, 6'd58, 6'd59:
                ent = mk(CLS_OP, IMM_IMM5, DST_C, priv_op);
            6'd29:
                ent = mk(CLS_OP, IMM_IMM5, DST_LINK, 1'b0);
            6'd1, 6'd5, 6'd9, 6'd13, 6'd20, 6'd45, 6'd46, 6'd52, 6'd54:
                ent = mk(CLS_OP, IMM_IMM5, DST_NONE, priv_op);
            6'd4, 6'd12, 6'd41:
                ent = mk(CLS_NOP, IMM_NONE, DST_NONE, 1'b0);
            default:
                ent = mk(CLS_ILLEGAL, IMM_NONE, DST_NONE, 1'b0);
        endcase
    end

endmodule

// File: rtl/insn_imm_gen.sv
// Module: resolves the immediate of the selected layout under the
// extension mode chosen by the table entry. Assumes the immediate fields
// are already sliced.
module insn_imm_gen
    import insn_dec_pkg::*;
(
    input  imm_mode_e          mode,
    input  logic [IMM_S_W-1:0] imm16,
    input  logic [IMM_R_W-1:0] imm5,
    input  logic [IMM_J_W-1:0] imm26,
    output logic [WORD_W-1:0]  imm
);

    localparam int PAD16 = WORD_W - IMM_S_W;
    localparam int PAD5  = WORD_W - IMM_R_W;
    localparam int PAD26 = WORD_W - IMM_J_W;

    // Extension multiplexer.
    always_comb begin
        case (mode)
            IMM_SEXT:  imm = {{PAD16{imm16[IMM_S_W-1]}}, imm16};
            IMM_ZEXT:  imm = {{PAD16{1'b0}}, imm16};
            IMM_HIGH:  imm = {imm16, {PAD16{1'b0}}};
            IMM_IMM5:  imm = {{PAD5{1'b0}}, imm5};
            IMM_IMM26: imm = {{PAD26{1'b0}}, imm26};
            default:   imm = '0;
        endcase
    end

endmodule

// File: rtl/insn_decoder.sv
// Module: top of the instruction field decoder. Combines the two opcode
// tables, resolves faults, destination and immediate, and registers the
// result one cycle behind the input strobe. Assumes user_mode is valid
// together with in_valid.
module insn_decoder
    import insn_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic              user_mode,
    output logic              out_valid,
    output logic [6:0]        op_id,
    output logic [31:0]       imm,
    output logic [4:0]        reg_a,
    output logic [4:0]        reg_b,
    output logic [4:0]        reg_c,
    output logic [4:0]        dest,
    output logic              wr_en,
    output logic              fault_illegal,
    output logic              fault_unimpl,
    output logic              fault_priv
);

    logic [OPC_W-1:0]   f_opc, f_opx, p_norm;
    logic [REG_W-1:0]   f_ra, f_rb, f_rc, tgt;
    logic [IMM_S_W-1:0] f_imm16;
    logic [IMM_R_W-1:0] f_imm5;
    logic [IMM_J_W-1:0] f_imm26;
    logic [WORD_W-1:0]  imm_raw;
    dec_entry_t         p_ent, x_ent, sel_ent;
    logic               is_rfmt;

    logic [OPID_W-1:0]  n_opid;
    logic [WORD_W-1:0]  n_imm;
    logic [REG_W-1:0]   n_dest;
    logic               n_wr, n_ill, n_uni, n_prv, quiet;

    insn_fields u_fields (
        .word  (insn),
        .opc   (f_opc),
        .opx   (f_opx),
        .ra    (f_ra),
        .rb    (f_rb),
        .rc    (f_rc),
        .imm16 (f_imm16),
        .imm5  (f_imm5),
        .imm26 (f_imm26)
    );

    insn_prim_tbl u_prim (
        .opc      (f_opc),
        .ent      (p_ent),
        .opc_norm (p_norm),
        .is_rfmt  (is_rfmt)
    );

    insn_ext_tbl u_ext (
        .opx (f_opx),
        .ent (x_ent)
    );

    insn_imm_gen u_imm (
        .mode  (sel_ent.imm_mode),
        .imm16 (f_imm16),
        .imm5  (f_imm5),
        .imm26 (f_imm26),
        .imm   (imm_raw)
    );

    // Picks the table entry: the extended table when the primary escapes.
    always_comb sel_ent = is_rfmt ? x_ent : p_ent;

    // Fault classification; the three flags come from distinct classes (R11-R13).
    always_comb begin
        n_ill = (sel_ent.cls == CLS_ILLEGAL);
        n_uni = (sel_ent.cls == CLS_UNIMPL);
        n_prv = (sel_ent.cls == CLS_OP) && sel_ent.priv && user_mode;
        quiet = n_ill || n_uni || n_prv || (sel_ent.cls == CLS_NOP);
    end

    // Destination selection and write enable (R9).
    always_comb begin
        case (sel_ent.dst)
            DST_B:    tgt = f_rb;
            DST_C:    tgt = f_rc;
            DST_LINK: tgt = LINK_REG;
            default:  tgt = '0;
        endcase
    end

    // Next-state values, forced to the quiet encoding for no-ops and faults (R10, R14).
    always_comb begin
        if (quiet) begin
            n_opid = OPID_NOP;
            n_imm  = '0;
            n_dest = '0;
            n_wr   = 1'b0;
        end else begin
            n_opid = is_rfmt ? {1'b1, f_opx} : {1'b0, p_norm};
            n_imm  = imm_raw;
            n_dest = tgt;
            n_wr   = (sel_ent.dst != DST_NONE) && (tgt != '0);
        end
    end

    // Output register: captures on the strobe, holds otherwise (R1, R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            op_id         <= '0;
            imm           <= '0;
            reg_a         <= '0;
            reg_b         <= '0;
            reg_c         <= '0;
            dest          <= '0;
            wr_en         <= 1'b0;
            fault_illegal <= 1'b0;
            fault_unimpl  <= 1'b0;
            fault_priv    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                op_id         <= n_opid;
                imm           <= n_imm;
                reg_a         <= f_ra;
                reg_b         <= f_rb;
                reg_c         <= f_rc;
                dest          <= n_dest;
                wr_en         <= n_wr;
                fault_illegal <= n_ill;
                fault_unimpl  <= n_uni;
                fault_priv    <= n_prv;
            end
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(op_id) && $stable(imm) && $stable(wr_en) && $stable(dest)));

    a_r14_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_illegal || fault_unimpl || fault_priv) |-> (!wr_en && op_id == OPID_NOP && imm == '0 && dest == '0));

    a_r14_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fault_illegal, fault_unimpl, fault_priv}) <= 1);

    a_r9_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (dest != '0));

    a_r13_priv_from_user: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fault_priv) |-> $past(user_mode));

endmodule

// File: tb/insn_decoder_test.sv
`timescale 1ns/1ps
module insn_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic        user_mode = 1'b0;
    logic        out_valid, wr_en, fault_illegal, fault_unimpl, fault_priv;
    logic [6:0]  op_id;
    logic [31:0] imm;
    logic [4:0]  reg_a, reg_b, reg_c, dest;

    int n_cmp = 0;
    int n_bad = 0;

    logic [6:0]  e_op;
    logic [31:0] e_imm;
    logic [4:0]  e_dest;
    logic        e_wr, e_ill, e_uni, e_prv;
    string       t_op, t_imm, t_flag;

    insn_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .user_mode(user_mode), .out_valid(out_valid), .op_id(op_id),
        .imm(imm), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
        .dest(dest), .wr_en(wr_en), .fault_illegal(fault_illegal),
        .fault_unimpl(fault_unimpl), .fault_priv(fault_priv)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    task automatic model(input logic [31:0] w, input logic u);
        int cat, md, ds;
        bit pv, io;
        logic [5:0] p, x;
        logic [4:0] tg;
        p = w[5:0]; x = w[16:11];
        cat = 0; md = 0; ds = 0; pv = 0; io = 0;
        if (p == 6'd58) begin
            md = 4; t_op = "R5";
            case (x)
                2, 3, 6, 7, 8, 11, 14, 16, 18, 19, 22, 23, 24, 26, 27, 28, 30, 31,
                32, 36, 37, 38, 39, 40, 48, 49, 57, 58, 59: ds = 2;
                29: ds = 3;
                1, 5, 9, 13, 20, 45, 46, 52, 54: ds = 0;
                4, 12, 41: cat = 1;
                default: cat = 2;
            endcase
            pv = (x == 1 || x == 9 || x == 20 || x == 38 || x == 46);
            e_op = {1'b1, x};
        end else begin
            t_op = "R4";
            case (p)
                0: begin md = 5; ds = 3; end
                1: md = 5;
                3, 7, 11, 15, 23, 4, 36, 8, 16, 24, 32: begin md = 1; ds = 1; end
                35, 39, 43, 47, 55: begin md = 1; ds = 1; io = 1; end
                5, 13, 21, 6, 14, 22, 30, 38, 46, 54: md = 1;
                37, 45, 53: begin md = 1; io = 1; end
                12, 20, 28, 40, 48: begin md = 2; ds = 1; end
                44, 52, 60: begin md = 3; ds = 1; end
                56: begin md = 1; ds = 1; pv = 1; end
                19, 27, 51, 59: cat = 1;
                50: cat = 3;
                default: cat = 2;
            endcase
            e_op = {1'b0, io ? p - 6'd32 : p};
        end
        e_ill = (cat == 2); e_uni = (cat == 3); e_prv = (cat == 0) && pv && u;
        case (md)
            1: begin e_imm = {{16{w[21]}}, w[21:6]}; t_imm = "R6"; end
            2: begin e_imm = {16'h0, w[21:6]}; t_imm = "R7"; end
            3: begin e_imm = {w[21:6], 16'h0}; t_imm = "R8"; end
            4: begin e_imm = {27'h0, w[10:6]}; t_imm = "R7"; end
            5: begin e_imm = {6'h0, w[31:6]}; t_imm = "R7"; end
            default: begin e_imm = '0; t_imm = "R7"; end
        endcase
        tg = (ds == 1) ? w[26:22] : (ds == 2) ? w[21:17] : (ds == 3) ? 5'd31 : 5'd0;
        e_dest = tg; e_wr = (ds != 0) && (tg != 0);
        t_flag = e_ill ? "R11" : e_uni ? "R12" : e_prv ? "R13" : "R10";
        if (cat != 0 || e_prv) begin
            e_op = 7'h7F; e_imm = '0; e_dest = '0; e_wr = 1'b0;
            t_op = (cat == 1) ? "R10" : "R14"; t_imm = t_op;
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic u);
        @(negedge clk);
        insn = w; user_mode = u; in_valid = 1'b1;
        model(w, u);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        chk("R2 out_valid", {31'h0, out_valid}, 32'h1);
        chk({t_op, " op_id"}, {25'h0, op_id}, {25'h0, e_op});
        chk({t_imm, " imm"}, imm, e_imm);
        chk("R3 regs", {17'h0, reg_a, reg_b, reg_c}, {17'h0, w[31:27], w[26:22], w[21:17]});
        chk("R9 dest/wr_en", {26'h0, dest, wr_en}, {26'h0, e_dest, e_wr});
        chk({t_flag, " flags"}, {29'h0, fault_illegal, fault_unimpl, fault_priv},
            {29'h0, e_ill, e_uni, e_prv});
        chk("R14 one flag", {31'h0, ($countones({fault_illegal, fault_unimpl, fault_priv}) <= 1)}, 32'h1);
    endtask

    // Idle cycle with a changed word: nothing may move (R2).
    task automatic idle_check();
        insn = ~insn;
        user_mode = ~user_mode;
        @(posedge clk);
        #1;
        chk("R2 idle out_valid", {31'h0, out_valid}, 32'h0);
        chk("R2 idle op_id", {25'h0, op_id}, {25'h0, e_op});
        chk("R2 idle imm", imm, e_imm);
        chk("R2 idle wr_en", {31'h0, wr_en}, {31'h0, e_wr});
    endtask

    function automatic logic [31:0] iw(input logic [4:0] a, input logic [4:0] b,
                                       input logic [15:0] i, input logic [5:0] op);
        return {a, b, i, op};
    endfunction

    function automatic logic [31:0] rw(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c,
                                       input logic [5:0] x, input logic [4:0] i5);
        return {a, b, c, x, i5, 6'd58};
    endfunction

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        in_valid = 1'b1;
        insn = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset out_valid", {31'h0, out_valid}, 32'h0);
        chk("R1 reset op/imm", {25'h0, op_id} | imm, 32'h0);
        chk("R1 reset regs/flags", {11'h0, reg_a, reg_b, reg_c, dest, wr_en,
            fault_illegal, fault_unimpl, fault_priv}, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners.
        apply(iw(5'd3, 5'd0, 16'h8001, 6'd4), 1'b0);        // R9 addi to r0: no write
        apply(iw(5'd3, 5'd7, 16'h8001, 6'd4), 1'b0);        // R6 negative sext
        apply(iw(5'd1, 5'd2, 16'hABCD, 6'd44), 1'b0);       // R8 high half
        apply(iw(5'd1, 5'd2, 16'h8001, 6'd20), 1'b0);       // R7 zext
        idle_check();
        apply(iw(5'd4, 5'd9, 16'hFFF0, 6'd55), 1'b0);       // R4 I/O variant folds to 23
        apply(iw(5'd4, 5'd9, 16'h0010, 6'd37), 1'b1);       // R4 I/O store
        apply(32'hFFFF_FFC0, 1'b0);                          // R7 R9 call: imm26, dest 31
        apply(iw(5'd6, 5'd6, 16'h1234, 6'd50), 1'b0);       // R12 unimplemented
        apply(iw(5'd6, 5'd6, 16'h1234, 6'd19), 1'b1);       // R10 cache no-op
        apply(iw(5'd6, 5'd6, 16'h1234, 6'd2), 1'b0);        // R11 illegal primary
        apply(rw(5'd1, 5'd2, 5'd3, 6'd63, 5'd4), 1'b0);     // R11 illegal extended
        apply(rw(5'd1, 5'd2, 5'd3, 6'd41, 5'd4), 1'b0);     // R10 extended no-op
        apply(rw(5'd1, 5'd2, 5'd3, 6'd1, 5'd0), 1'b1);      // R13 return from exception, user
        apply(rw(5'd1, 5'd2, 5'd3, 6'd1, 5'd0), 1'b0);      // R13 same, supervisor
        apply(rw(5'd1, 5'd2, 5'd5, 6'd38, 5'd9), 1'b0);     // R5 control read writes rc
        apply(iw(5'd1, 5'd8, 16'hFFFE, 6'd56), 1'b1);       // R13 primary privileged, user
        apply(rw(5'd1, 5'd2, 5'd0, 6'd49, 5'd0), 1'b0);     // R9 add to r0
        apply(rw(5'd1, 5'd2, 5'd3, 6'd29, 5'd0), 1'b0);     // R9 callr link
        idle_check();

        // Seeded random sweep of both tables.
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom % 5 < 2) w[5:0] = 6'd58;
            apply(w, 1'($urandom % 2));
            if (k % 7 == 0) idle_check();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule